// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a slave serial port. An external controller uses it to read and write a small bank of configuration and status registers. The controller pulls an active-low enable low to begin an access and toggles a serial clock. It sends every bit on one input line and receives read data on an output that is driven only while that data is being shifted. Because the output is otherwise released, the input and output lines may share a single wire. The enable also works as a device select, so several ports can share the clock and data lines.

Each access is one frame. The first bit is the direction, then seven address bits, then eight data bits. Address and data both travel least significant bit first. The serial pins are oversampled in the system clock domain. A port-select input chooses between two sources of configuration. When it is high, configuration comes from the serial port. When it is low, configuration comes straight from hardware pins. On reset, the configuration registers load their defaults from those pins.

Top module: `ser_cfg_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, the configuration register loads `pin_ref` and `pin_mon`, with a pin value of 01 loaded as 00. `sdo_oe` is low after reset.
- R2: A frame is sampled on rising `sclk` edges while `sen_n` is low. Bit 0 is the direction (1 = read, 0 = write), bits 1..7 are the address LSB first, and bits 8..15 are the data LSB first. A write to address 0 updates `cfg_ref` from data bits [1:0] and `cfg_mon` from data bit 2 after the 16th rising edge.
- R3: Read data leaves on `sdo` LSB first, one bit launched on each falling `sclk` edge. Data bit 0 is launched on the falling edge that follows the 8th rising edge.
- R4: `sdo_oe` is high only in a read frame, from the falling edge after the 8th rising edge until the falling edge after the 16th rising edge. It is low in write frames and while idle.
- R5: If `sen_n` rises before the 16th rising edge, the frame is dropped: no register changes and `sdo_oe` goes low.
- R6: The reference-select field accepts only 00, 10 and 11. A write carrying 01 in bits [1:0] leaves the field unchanged, while bit 2 is still written.
- R7: A read of address 1 returns `stat_in` as it stands just after the 8th rising edge. Writes to address 1 change nothing.
- R8: Addresses other than 0 and 1 read as 0x00, and writes to them change nothing.
- R9: While `port_sel` is low, `cfg_ref` and `cfg_mon` follow the pins (01 shown as 00), frames are ignored, and `sdo_oe` stays low.
- R10: Rising edges after the 16th within one enable period are ignored: there is no second write and `sdo_oe` stays low.
- R11: A read of address 0 returns bits [7:3] as 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 12 times the serial clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 1 | High: serial port owns the configuration; low: pins own it |
| pin_ref | input | 2 | Reference-select default / pin-mode value |
| pin_mon | input | 1 | Monitor-enable default / pin-mode value |
| stat_in | input | 8 | Status byte returned at address 1 |
| sclk | input | 1 | Serial clock, idle low |
| sen_n | input | 1 | Active-low frame enable and device select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the sdo pad driver |
| cfg_ref | output | 2 | Active reference-select field |
| cfg_mon | output | 1 | Active monitor-enable bit |

## Verification
A miscounted bit position in the frame shows at the ports as a write landing with wrong field values. It also shows as `sdo_oe` rising one serial half-period early or late. Both become visible within a few system clocks of the offending serial edge. A stale read snapshot or a wrong shift direction appears on `sdo` at the very next falling edge. A commit that escapes an aborted or over-clocked frame changes `cfg_ref` or `cfg_mon` within a few clocks of the frame's end. The reference model compares all four outputs on every settled clock, so each of these faults is caught in the bit time where it arises.

// File: rtl/ser_cfg_pkg.sv
// Shared constants and helpers for the serial configuration port.
// Assumes an 8-bit or wider data path so that the field positions fit.
package ser_cfg_pkg;

    typedef enum logic [1:0] {
        REF_LOW  = 2'b00,
        REF_RSV  = 2'b01,
        REF_MID  = 2'b10,
        REF_HIGH = 2'b11
    } refsel_t;

    localparam int unsigned CFG_ADDR  = 0;
    localparam int unsigned STAT_ADDR = 1;
    localparam int unsigned REF_LSB   = 0;
    localparam int unsigned MON_BIT   = 2;

    // Map the reserved reference code onto the lowest legal one.
    function automatic logic [1:0] ref_legal(input logic [1:0] p);
        return (p == REF_RSV) ? REF_LOW : p;
    endfunction

endpackage

// File: rtl/ssp_sync.sv
// Multi-stage synchronizer for asynchronous serial pins.
// Each bit passes through STAGES flops; RST_VAL gives the idle level per bit.
module ssp_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < int'(STAGES); g++) begin : g_stage
            // Shift the pin levels one stage further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else if (g == 0) stg[g] <= d;
                else stg[g] <= stg[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ssp_frame.sv
// Frame sequencer: counts serial clock edges, assembles the direction,
// address and data fields, issues the write strobe and the read-load
// request, and shifts read data out on falling serial edges.
// Assumes synchronized inputs and a serial clock that is idle low.
module ssp_frame #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sclk_s,
    input  logic              sen_n_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              sdo,
    output logic              sdo_oe
);

    localparam int unsigned HDR_LEN   = 1 + ADDR_W;
    localparam int unsigned FRAME_LEN = HDR_LEN + DATA_W;
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);

    logic              sclk_d;
    logic              rise, fall, in_frame;
    logic [CNT_W-1:0]  cnt;
    logic              rw;
    logic              rd_req;
    logic [DATA_W-1:0] shreg;

    assign rise     = sclk_s & ~sclk_d;
    assign fall     = ~sclk_s & sclk_d;
    assign in_frame = active & ~sen_n_s;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Count rising edges and shift the incoming bits into their fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            rw    <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else if (!in_frame) begin
            cnt <= '0;
        end else if (rise && cnt != CNT_W'(FRAME_LEN)) begin
            if (cnt == '0)                     rw    <= sdi_s;
            else if (cnt < CNT_W'(HDR_LEN))    addr  <= {sdi_s, addr[ADDR_W-1:1]};
            else                               wdata <= {sdi_s, wdata[DATA_W-1:1]};
            cnt <= cnt + 1'b1;
        end
    end

    // Raise one-cycle strobes once the header or the whole frame is in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb <= 1'b0;
            rd_req <= 1'b0;
        end else begin
            wr_stb <= in_frame & rise & (cnt == CNT_W'(FRAME_LEN - 1)) & ~rw;
            rd_req <= in_frame & rise & (cnt == CNT_W'(HDR_LEN - 1)) & rw;
        end
    end

    // Load the read snapshot and launch one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            sdo    <= 1'b0;
            sdo_oe <= 1'b0;
        end else if (!in_frame) begin
            sdo_oe <= 1'b0;
        end else if (rd_req) begin
            shreg <= rd_data;
        end else if (fall) begin
            if (rw && cnt >= CNT_W'(HDR_LEN) && cnt < CNT_W'(FRAME_LEN)) begin
                sdo    <= shreg[0];
                shreg  <= shreg >> 1;
                sdo_oe <= 1'b1;
            end else begin
                sdo_oe <= 1'b0;
            end
        end
    end

    // R4: the output is enabled only in the data phase of a read frame
    a_r4_oe_read_data: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (rw && cnt >= CNT_W'(HDR_LEN)));

    // R5: losing the enable releases the output on the next cycle
    a_r5_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |=> !sdo_oe);

    // R3: a launched bit holds until the next falling edge
    a_r3_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !fall && !rd_req && in_frame) |=> $stable(sdo));

    // R2: a commit happens only at the end of a full frame
    a_r2_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (cnt == CNT_W'(FRAME_LEN)));

    // R10: one frame produces at most one commit
    a_r10_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/ssp_regbank.sv
// Register bank: a configuration register at one address and a read-only
// status register at another; all other addresses read zero.
// Defaults come from the pins while reset is held.
module ssp_regbank
    import ser_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_sel,
    input  logic [1:0]        pin_ref,
    input  logic              pin_mon,
    input  logic [DATA_W-1:0] stat_in,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        cfg_ref,
    output logic              cfg_mon
);

    logic [1:0] ref_q;
    logic       mon_q;
    logic       cfg_hit;

    assign cfg_hit = (addr == ADDR_W'(CFG_ADDR));

    // Load pin defaults in reset, then accept writes to the config address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= ref_legal(pin_ref);
            mon_q <= pin_mon;
        end else if (wr_stb && port_sel && cfg_hit) begin
            mon_q <= wdata[MON_BIT];
            if (wdata[REF_LSB+1:REF_LSB] != REF_RSV) ref_q <= wdata[REF_LSB+1:REF_LSB];
        end
    end

    // Select the read value for the addressed register.
    always_comb begin
        rd_data = '0;
        if (cfg_hit) begin
            rd_data[REF_LSB+1:REF_LSB] = ref_q;
            rd_data[MON_BIT]           = mon_q;
        end else if (addr == ADDR_W'(STAT_ADDR)) begin
            rd_data = stat_in;
        end
    end

    // Choose the configuration source according to the port select.
    always_comb begin
        cfg_ref = port_sel ? ref_q : ref_legal(pin_ref);
        cfg_mon = port_sel ? mon_q : pin_mon;
    end

    // R6: the reserved reference code is never stored
    a_r6_ref_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ref_q != REF_RSV);

    // R8: without a config-address write the register holds its value
    a_r8_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && cfg_hit) |=> $stable({ref_q, mon_q}));

endmodule

// File: rtl/ser_cfg_port.sv
// Top of the serial configuration port. Oversamples the serial pins in the
// system clock domain, sequences frames and holds the register bank.
// Assumes clk runs at least 12 times faster than sclk and that port_sel
// changes only while no frame is in progress.
module ser_cfg_port #(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_sel,
    input  logic [1:0]        pin_ref,
    input  logic              pin_mon,
    input  logic [DATA_W-1:0] stat_in,
    input  logic              sclk,
    input  logic              sen_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [1:0]        cfg_ref,
    output logic              cfg_mon
);

    logic [2:0]        pins_s;
    logic              wr_stb;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rd_data;

    ssp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({sclk, sen_n, sdi}),
        .q    (pins_s)
    );

    ssp_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (port_sel),
        .sclk_s (pins_s[2]),
        .sen_n_s(pins_s[1]),
        .sdi_s  (pins_s[0]),
        .rd_data(rd_data),
        .wr_stb (wr_stb),
        .addr   (addr),
        .wdata  (wdata),
        .sdo    (sdo),
        .sdo_oe (sdo_oe)
    );

    ssp_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_sel(port_sel),
        .pin_ref (pin_ref),
        .pin_mon (pin_mon),
        .stat_in (stat_in),
        .wr_stb  (wr_stb),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .cfg_ref (cfg_ref),
        .cfg_mon (cfg_mon)
    );

    // R9: in pin mode the output is never enabled
    a_r9_pin_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !port_sel |=> !sdo_oe);

endmodule

// File: tb/test_ser_cfg_port.sv
module test_ser_cfg_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_sel = 1'b1;
    logic [1:0] pin_ref = 2'b01;
    logic       pin_mon = 1'b1;
    logic [7:0] stat_in = 8'h00;
    logic       sclk = 1'b0;
    logic       sen_n = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo, sdo_oe, cfg_mon;
    logic [1:0] cfg_ref;

    ser_cfg_port i_ser_cfg_port (
        .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .pin_ref(pin_ref),
        .pin_mon(pin_mon), .stat_in(stat_in), .sclk(sclk), .sen_n(sen_n),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .cfg_ref(cfg_ref), .cfg_mon(cfg_mon)
    );

    always #2 clk = ~clk;   // 250 MHz

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // behavioural model state
    int       m_cnt = 0;
    bit       m_rw;
    int       m_addr, m_data;
    bit [1:0] m_ref;
    bit       m_mon;
    bit [7:0] m_shift;
    bit       e_oe = 0;
    bit       e_sdo = 0;

    function automatic bit [1:0] legal(input bit [1:0] v);
        return (v == 2'b01) ? 2'b00 : v;
    endfunction

    function automatic bit [7:0] m_read(input int a);
        if (a == 0) return {5'b0, m_mon, m_ref};
        if (a == 1) return stat_in;
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit [1:0] er = port_sel ? m_ref : legal(pin_ref);
        bit       em = port_sel ? m_mon : pin_mon;
        chk(sdo_oe == e_oe, "sdo_oe", sdo_oe, e_oe);
        if (e_oe) chk(sdo == e_sdo, "sdo", sdo, e_sdo);
        chk(cfg_ref == er, "cfg_ref", cfg_ref, er);
        chk(cfg_mon == em, "cfg_mon", cfg_mon, em);
    endtask

    task automatic tick(input int n, input bit cmp);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cmp) compare();
        end
    endtask

    task automatic settle();
        tick(7, 0);
        tick(5, 1);
    endtask

    task automatic m_rise(input bit b);
        if (sen_n || !port_sel || m_cnt >= 16) return;
        if (m_cnt == 0) m_rw = b;
        else if (m_cnt < 8) m_addr |= int'(b) << (m_cnt - 1);
        else m_data |= int'(b) << (m_cnt - 8);
        m_cnt++;
        if (m_cnt == 8 && m_rw) m_shift = m_read(m_addr);
        if (m_cnt == 16 && !m_rw && m_addr == 0) begin
            m_mon = m_data[2];
            if (m_data[1:0] != 2'b01) m_ref = m_data[1:0];
        end
    endtask

    task automatic m_fall();
        if (sen_n || !port_sel) return;
        if (m_rw && m_cnt >= 8 && m_cnt < 16) begin
            e_oe = 1;
            e_sdo = m_shift[m_cnt - 8];
        end else e_oe = 0;
    endtask

    task automatic do_reset(input bit [1:0] pr, input bit pm);
        pin_ref = pr; pin_mon = pm;
        rst_n = 0;
        tick(5, 0);
        m_ref = legal(pr); m_mon = pm; m_cnt = 0; e_oe = 0;
        rst_n = 1;
        settle();
    endtask

    // nrise rising edges of a frame; bits past the 16th are ones
    task automatic frame(input bit rw, input int a, input int d, input int nrise);
        sen_n = 0; m_cnt = 0; m_addr = 0; m_data = 0; m_rw = 0;
        settle();
        for (int i = 0; i < nrise; i++) begin
            bit b;
            if (i == 0) b = rw;
            else if (i < 8) b = a[i-1];
            else if (i < 16) b = d[i-8];
            else b = 1'b1;
            sdi = b;
            tick(4, 1);
            sclk = 1; m_rise(b);
            settle();
            sclk = 0; m_fall();
            settle();
        end
        sen_n = 1; m_cnt = 0; e_oe = 0;
        settle();
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        cur_req = "R1";
        do_reset(2'b01, 1'b1);
        chk(cfg_ref == 2'b00 && cfg_mon == 1'b1 && !sdo_oe, "reset cfg", {cfg_ref, cfg_mon}, 3'b001);

        cur_req = "R2";
        frame(0, 0, 8'h03, 16);
        chk(cfg_ref == 2'b11 && cfg_mon == 1'b0, "write cfg", {cfg_ref, cfg_mon}, 3'b110);

        cur_req = "R3";
        frame(1, 0, 0, 16);
        cur_req = "R4";
        frame(0, 0, 8'h07, 16);
        chk(!sdo_oe, "oe after write", sdo_oe, 0);

        cur_req = "R11";
        frame(0, 0, 8'hFE, 16);
        frame(1, 0, 0, 16);

        cur_req = "R6";
        frame(0, 0, 8'h01, 16);
        chk(cfg_ref == 2'b10 && cfg_mon == 1'b0, "rsv code", {cfg_ref, cfg_mon}, 3'b100);
        frame(0, 0, 8'h00, 16);
        chk(cfg_ref == 2'b00, "ref 00", cfg_ref, 0);

        cur_req = "R7";
        stat_in = 8'hA5;
        frame(0, 1, 8'h55, 16);
        frame(1, 1, 0, 16);
        stat_in = 8'h3C;
        frame(1, 1, 0, 16);
        frame(1, 0, 0, 16);

        cur_req = "R8";
        frame(0, 7'h45, 8'hFF, 16);
        frame(1, 7'h45, 0, 16);
        frame(1, 0, 0, 16);
        chk(cfg_ref == 2'b00 && cfg_mon == 1'b0, "unmapped write", {cfg_ref, cfg_mon}, 0);

        cur_req = "R5";
        frame(0, 0, 8'h07, 12);
        chk(cfg_ref == 2'b00 && cfg_mon == 1'b0, "aborted write", {cfg_ref, cfg_mon}, 0);
        frame(0, 0, 8'h07, 15);
        chk(cfg_ref == 2'b00, "abort at 15", cfg_ref, 0);
        frame(1, 1, 0, 11);
        chk(!sdo_oe, "oe after abort", sdo_oe, 0);

        cur_req = "R10";
        frame(0, 0, 8'h02, 22);
        chk(cfg_ref == 2'b10 && cfg_mon == 1'b0, "extra edges", {cfg_ref, cfg_mon}, 3'b100);
        frame(1, 0, 0, 20);

        cur_req = "R9";
        port_sel = 0;
        pin_ref = 2'b11; pin_mon = 1'b1;
        settle();
        frame(0, 0, 8'h00, 16);
        frame(1, 0, 0, 16);
        pin_ref = 2'b01;
        settle();
        chk(cfg_ref == 2'b00 && cfg_mon == 1'b1, "pin mode", {cfg_ref, cfg_mon}, 3'b001);
        port_sel = 1;
        settle();
        chk(cfg_ref == 2'b10 && cfg_mon == 1'b0, "regs kept", {cfg_ref, cfg_mon}, 3'b100);

        cur_req = "R1";
        do_reset(2'b11, 1'b0);
        chk(cfg_ref == 2'b11 && cfg_mon == 1'b0, "reset 11", {cfg_ref, cfg_mon}, 3'b110);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule